// File: doc/BRIEF.md
# External SRAM Bus-Cycle Controller

This block turns one internal read or write request into an SRAM-style cycle on an external bus. Each request belongs to one chip-select area. The block compares three upper physical address bits with a fixed area code. A request outside the area is dropped. A request inside the area starts a cycle with four parts:

- an address setup phase, with chip select low and both strobes high;
- a strobe phase, with the read strobe (also usable as output enable) low or some active-low write enables low;
- a hold phase, with chip select still low and both strobes high;
- a one-cycle completion pulse.

Setup, hold and wait counts come from configuration inputs. The bus width (8, 16 or 32 bits) comes from a configuration input and, with the access size and address, picks the byte lanes. An active-low bus-start strobe marks the beginning of each cycle. That strobe can be stretched by one cycle when the setup count is nonzero. An external ready input passes through a two-stage synchronizer. Once the programmed waits are used up, the strobe phase keeps going while that input is low. When the wait count is zero, the ready input has no effect.

The block accepts a new request only while `req_ready` is high. It captures the address, write data, lane mask and all timing settings at that moment. Configuration changes during a cycle therefore take effect only on the next request.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A request whose address bits 28..26 differ from the area code (default 3'b110) starts no cycle: `bus_cs_n` stays high, `done` stays low and `req_ready` stays high.
- R2: After acceptance, `bus_cs_n` is low with both strobes inactive for exactly `cfg_setup` cycles (0 to 7) before the strobe phase.
- R3: With ready asserted, the strobe phase lasts 1 + `cfg_wait` cycles. A `cfg_wait` above 25 is treated as 25.
- R4: With `cfg_wait` nonzero, the strobe phase is extended while the synchronized ready is low. If `ext_rdy` rises during strobe cycle K (with K above `cfg_wait`), the strobe phase lasts K + 2 cycles.
- R5: With `cfg_wait` = 0, the strobe phase lasts exactly one cycle, whatever the level of `ext_rdy`.
- R6: After the strobe phase, `bus_cs_n` stays low with both strobes inactive for exactly `cfg_hold` cycles (0 to 7).
- R7: `bus_bs_n` is low for the first cycle of the access. It is low for two cycles when `cfg_bs_hold` = 1 and `cfg_setup` >= 1.
- R8: Lane selection uses these encodings:
  - `req_size` 0 = byte, 1 = halfword, 2 = word.
  - `cfg_width` 0 = 8, 1 = 16, 2 = 32 bits.
  - The access size is clamped to the bus width.
  - The lane offset is `req_addr[1:0]`, taken modulo the bus width in bytes and aligned down to the clamped size.
  - Lane i drives `bus_we_n[i]`.
- R9: During a read strobe, `bus_rd_n` is low and every `bus_we_n` bit is high. During a write strobe, `bus_rd_n` is high and only the selected `bus_we_n` bits are low. `bus_addr`, `bus_wdata`, the lane mask and the timing settings keep the values captured at acceptance for the whole cycle.
- R10: `rd_data` takes `bus_rdata` as sampled on the last strobe cycle. `done` is high for exactly one cycle, the first cycle with `bus_cs_n` high again, and `req_ready` is low throughout the access.
- R11: After reset, the outputs are idle: `bus_cs_n`, `bus_rd_n`, `bus_bs_n` and all `bus_we_n` bits are high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Physical byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| cfg_setup | input | 3 | Setup cycles |
| cfg_hold | input | 3 | Hold cycles |
| cfg_wait | input | 5 | Programmed wait cycles |
| cfg_bs_hold | input | 1 | Stretch the bus-start strobe by one cycle |
| cfg_width | input | 2 | Bus width code |
| ext_rdy | input | 1 | Asynchronous external ready, active high |
| bus_rdata | input | 32 | External read data |
| bus_cs_n | output | 1 | Area chip select, active low |
| bus_bs_n | output | 1 | Bus-start strobe, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | 4 | Per-lane write enables, active low |
| bus_addr | output | 29 | Held external address |
| bus_wdata | output | 32 | Held external write data |
| rd_data | output | 32 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the setup, strobe and hold phases cycle by cycle at zero, nonzero, maximum and over-range settings. A counter that is off by one, or a missing wait clamp, therefore shows up as a wrong phase length. It raises ready at a known strobe cycle and expects exactly two cycles of synchronizer latency. It also holds ready low with zero waits, which would hang a design that samples ready regardless of the wait count. Halfword accesses at odd addresses and narrow bus widths catch a lane mask that is not aligned or clamped. The bench changes the configuration in the middle of a cycle to catch settings that are not latched. Its read data is valid only while the read strobe is low, which catches data captured after the strobe ends.

// File: rtl/sram_cycle_pkg.sv
package sram_cycle_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam logic [1:0] WIDTH_8  = 2'd0;
  localparam logic [1:0] WIDTH_16 = 2'd1;
  localparam logic [1:0] WIDTH_32 = 2'd2;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/sram_rdy_sync.sv
module sram_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int LANES = 4
) (
  input  logic [1:0]       addr_lo,
  input  logic [1:0]       size,
  input  logic [1:0]       width,
  output logic [LANES-1:0] mask
);
  localparam int LANE_LOG = $clog2(LANES);

  always_comb begin
    int wlog;
    int slog;
    int nbytes;
    int offs;
    wlog = (int'(width) > LANE_LOG) ? LANE_LOG : int'(width);
    slog = (int'(size) > wlog) ? wlog : int'(size);
    nbytes = 1 << slog;
    offs = int'(addr_lo) & ((1 << wlog) - 1);
    offs = offs & ~(nbytes - 1);
    mask = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i >= offs && i < offs + nbytes) mask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_cycle_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int LANES    = 4,
  parameter int SETUP_W  = 3,
  parameter int HOLD_W   = 3,
  parameter int WAIT_W   = 5,
  parameter int WAIT_MAX = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 start_wr,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [8*LANES-1:0]   start_wdata,
  input  logic [LANES-1:0]     start_lanes,
  input  logic [SETUP_W-1:0]   cfg_setup,
  input  logic [HOLD_W-1:0]    cfg_hold,
  input  logic [WAIT_W-1:0]    cfg_wait,
  input  logic                 cfg_bs_hold,
  input  logic                 rdy_ok,
  input  logic [8*LANES-1:0]   bus_rdata,
  output logic                 idle,
  output logic                 bus_cs_n,
  output logic                 bus_bs_n,
  output logic                 bus_rd_n,
  output logic [LANES-1:0]     bus_we_n,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [8*LANES-1:0]   bus_wdata,
  output logic [8*LANES-1:0]   rd_data,
  output logic                 done
);
  localparam int CNT_A = (WAIT_W > SETUP_W) ? WAIT_W : SETUP_W;
  localparam int CNT_W = (CNT_A > HOLD_W) ? CNT_A : HOLD_W;

  phase_e             phase, nxt_phase;
  logic [CNT_W-1:0]   cnt, nxt_cnt;
  logic               fin;
  logic               wr_q, cur_wr, bs_left;
  logic [LANES-1:0]   lanes_q, cur_lanes;
  logic [HOLD_W-1:0]  hold_q;
  logic [WAIT_W-1:0]  wait_q, wait_c;
  logic               accept;

  assign wait_c    = (cfg_wait > WAIT_W'(WAIT_MAX)) ? WAIT_W'(WAIT_MAX) : cfg_wait;
  assign accept    = (phase == PH_IDLE) && start;
  assign cur_wr    = accept ? start_wr : wr_q;
  assign cur_lanes = accept ? start_lanes : lanes_q;

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt;
    fin       = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          if (cfg_setup != '0) begin
            nxt_phase = PH_SETUP;
            nxt_cnt   = CNT_W'(cfg_setup) - CNT_W'(1);
          end else begin
            nxt_phase = PH_STROBE;
            nxt_cnt   = CNT_W'(wait_c);
          end
        end
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          nxt_phase = PH_STROBE;
          nxt_cnt   = CNT_W'(wait_q);
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt != '0) begin
          nxt_cnt = cnt - CNT_W'(1);
        end else if (wait_q == '0 || rdy_ok) begin
          if (hold_q != '0) begin
            nxt_phase = PH_HOLD;
            nxt_cnt   = CNT_W'(hold_q) - CNT_W'(1);
          end else begin
            nxt_phase = PH_IDLE;
            fin       = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt == '0) begin
          nxt_phase = PH_IDLE;
          fin       = 1'b1;
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      lanes_q   <= '0;
      hold_q    <= '0;
      wait_q    <= '0;
      bs_left   <= 1'b0;
      idle      <= 1'b1;
      bus_cs_n  <= 1'b1;
      bus_bs_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_we_n  <= '1;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      phase <= nxt_phase;
      cnt   <= nxt_cnt;
      if (accept) begin
        wr_q      <= start_wr;
        lanes_q   <= start_lanes;
        hold_q    <= cfg_hold;
        wait_q    <= wait_c;
        bus_addr  <= start_addr;
        bus_wdata <= start_wdata;
        bus_bs_n  <= 1'b0;
        bs_left   <= cfg_bs_hold && (cfg_setup != '0);
      end else if (bs_left) begin
        bus_bs_n <= 1'b0;
        bs_left  <= 1'b0;
      end else begin
        bus_bs_n <= 1'b1;
      end
      if (phase == PH_STROBE && nxt_phase != PH_STROBE && !wr_q)
        rd_data <= bus_rdata;
      idle     <= (nxt_phase == PH_IDLE);
      bus_cs_n <= (nxt_phase == PH_IDLE);
      bus_rd_n <= !(nxt_phase == PH_STROBE && !cur_wr);
      bus_we_n <= (nxt_phase == PH_STROBE && cur_wr) ? ~cur_lanes : '1;
      done     <= fin;
    end
  end

  assert_wait_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && cnt == '0 && wait_q == '0) |=> (phase != PH_STROBE));

  assert_rdy_stretch_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && cnt == '0 && wait_q != '0 && !rdy_ok) |=> (phase == PH_STROBE));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (bus_we_n == '1));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_end_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_cs_n && $past(!bus_cs_n)));

  assert_bs_in_cs_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_bs_n |-> !bus_cs_n);
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int         ADDR_W    = 29,
  parameter int         LANES     = 4,
  parameter int         SETUP_W   = 3,
  parameter int         HOLD_W    = 3,
  parameter int         WAIT_W    = 5,
  parameter int         WAIT_MAX  = 25,
  parameter int         SYNC_LEN  = 2,
  parameter logic [2:0] AREA_CODE = 3'b110
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [8*LANES-1:0]  req_wdata,
  output logic                req_ready,
  input  logic [SETUP_W-1:0]  cfg_setup,
  input  logic [HOLD_W-1:0]   cfg_hold,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic                cfg_bs_hold,
  input  logic [1:0]          cfg_width,
  input  logic                ext_rdy,
  input  logic [8*LANES-1:0]  bus_rdata,
  output logic                bus_cs_n,
  output logic                bus_bs_n,
  output logic                bus_rd_n,
  output logic [LANES-1:0]    bus_we_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [8*LANES-1:0]  bus_wdata,
  output logic [8*LANES-1:0]  rd_data,
  output logic                done
);
  localparam int AREA_LSB = ADDR_W - 3;

  logic             hit;
  logic             rdy_ok;
  logic [LANES-1:0] lanes;

  assign hit = (req_addr[ADDR_W-1:AREA_LSB] == AREA_CODE);

  sram_rdy_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_rdy),
    .sync_out (rdy_ok)
  );

  sram_lane_mask #(.LANES(LANES)) u_lanes (
    .addr_lo (req_addr[1:0]),
    .size    (req_size),
    .width   (cfg_width),
    .mask    (lanes)
  );

  sram_cycle_fsm #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .SETUP_W  (SETUP_W),
    .HOLD_W   (HOLD_W),
    .WAIT_W   (WAIT_W),
    .WAIT_MAX (WAIT_MAX)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (req_valid && hit),
    .start_wr    (req_write),
    .start_addr  (req_addr),
    .start_wdata (req_wdata),
    .start_lanes (lanes),
    .cfg_setup   (cfg_setup),
    .cfg_hold    (cfg_hold),
    .cfg_wait    (cfg_wait),
    .cfg_bs_hold (cfg_bs_hold),
    .rdy_ok      (rdy_ok),
    .bus_rdata   (bus_rdata),
    .idle        (req_ready),
    .bus_cs_n    (bus_cs_n),
    .bus_bs_n    (bus_bs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_we_n    (bus_we_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rd_data     (rd_data),
    .done        (done)
  );

  assert_area_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !hit) |=> (req_ready && bus_cs_n));

  assert_lane_count_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($countones(lanes) == 1 || $countones(lanes) == 2 || $countones(lanes) == 4));
endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;
  localparam logic [2:0] AREA = 3'b110;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, cfg_bs_hold, ext_rdy;
  logic [28:0] req_addr;
  logic [1:0]  req_size, cfg_width;
  logic [31:0] req_wdata, rd_pat, bus_rdata;
  logic [2:0]  cfg_setup, cfg_hold;
  logic [4:0]  cfg_wait;
  logic        req_ready, bus_cs_n, bus_bs_n, bus_rd_n, done;
  logic [3:0]  bus_we_n;
  logic [28:0] bus_addr;
  logic [31:0] bus_wdata, rd_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  assign bus_rdata = bus_rd_n ? 32'hDEAD_BEEF : rd_pat;

  sram_cycle_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_ready(req_ready), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_wait(cfg_wait), .cfg_bs_hold(cfg_bs_hold), .cfg_width(cfg_width),
    .ext_rdy(ext_rdy), .bus_rdata(bus_rdata), .bus_cs_n(bus_cs_n),
    .bus_bs_n(bus_bs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // fields: wr[22] size[21:20] off[19:18] width[17:16] setup[15:13] hold[12:10] wait[9:5] bsh[4] lanes[3:0]
  localparam int NV = 9;
  localparam logic [22:0] VECS [NV] = '{
    {1'b1, 2'd0, 2'd0, 2'd2, 3'd0, 3'd0, 5'd0,  1'b0, 4'b0001},
    {1'b1, 2'd0, 2'd3, 2'd2, 3'd1, 3'd0, 5'd2,  1'b1, 4'b1000},
    {1'b0, 2'd1, 2'd2, 2'd2, 3'd7, 3'd7, 5'd0,  1'b0, 4'b1100},
    {1'b1, 2'd2, 2'd0, 2'd2, 3'd3, 3'd2, 5'd25, 1'b1, 4'b1111},
    {1'b1, 2'd0, 2'd3, 2'd1, 3'd2, 3'd1, 5'd1,  1'b0, 4'b0010},
    {1'b1, 2'd2, 2'd0, 2'd1, 3'd0, 3'd3, 5'd4,  1'b1, 4'b0011},
    {1'b1, 2'd1, 2'd1, 2'd0, 3'd5, 3'd0, 5'd0,  1'b0, 4'b0001},
    {1'b0, 2'd1, 2'd1, 2'd2, 3'd1, 3'd1, 5'd3,  1'b0, 4'b0011},
    {1'b1, 2'd1, 2'd1, 2'd2, 3'd1, 3'd1, 5'd31, 1'b0, 4'b0011}
  };

  task automatic run_access(input logic wr, input logic [1:0] sz, input logic [1:0] off,
                            input logic [1:0] wd, input int su, input int ho, input int wt,
                            input logic bsh, input logic [3:0] lanes, input int rdy_k,
                            input logic [31:0] pat);
    int n_su = 0, n_st = 0, n_ho = 0, n_bs = 0, guard = 0;
    int exp_st;
    logic early_done = 1'b0, ready_bad = 1'b0, lane_bad = 1'b0, hold_bad = 1'b0;
    logic [28:0] a;
    logic [31:0] wdat;
    a = {AREA, 24'h00A5C3, off};
    wdat = pat ^ 32'h0F0F_0F0F;
    exp_st = (rdy_k > 0) ? rdy_k + 2 : ((wt > 25) ? 26 : wt + 1);
    @(negedge clk);
    cfg_setup = 3'(su); cfg_hold = 3'(ho); cfg_wait = 5'(wt);
    cfg_bs_hold = bsh; cfg_width = wd;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = wdat; rd_pat = pat;
    @(negedge clk);
    req_valid = 1'b0;
    // scramble settings mid-cycle: captured values must hold (R9)
    cfg_setup = 3'd7; cfg_hold = 3'd7; cfg_wait = 5'd9; cfg_width = 2'd0;
    req_addr = 29'h0; req_wdata = 32'h0;
    while (!bus_cs_n && guard < 300) begin
      if (done) early_done = 1'b1;
      if (req_ready) ready_bad = 1'b1;
      if (!bus_bs_n) n_bs++;
      if (bus_addr !== a || (wr && bus_wdata !== wdat)) hold_bad = 1'b1;
      if (!bus_rd_n || bus_we_n != 4'hF) begin
        n_st++;
        if (wr && (bus_we_n !== ~lanes || !bus_rd_n)) lane_bad = 1'b1;
        if (!wr && (bus_we_n !== 4'hF || bus_rd_n)) lane_bad = 1'b1;
        if (rdy_k > 0 && n_st == rdy_k) ext_rdy = 1'b1;
      end else if (n_st == 0) n_su++;
      else n_ho++;
      guard++;
      @(negedge clk);
    end
    chk("R2 setup cycles", 32'(n_su), 32'(su));
    chk("R3/R4/R5 strobe cycles", 32'(n_st), 32'(exp_st));
    chk("R6 hold cycles", 32'(n_ho), 32'(ho));
    chk("R7 bus-start cycles", 32'(n_bs), (bsh && su > 0) ? 32'd2 : 32'd1);
    chk("R8/R9 lane and strobe pattern", 32'(lane_bad), 32'd0);
    chk("R9 address/data held", 32'(hold_bad), 32'd0);
    chk("R10 ready low and no early done", 32'(ready_bad | early_done), 32'd0);
    chk("R10 done at end", 32'(done), 32'd1);
    if (!wr) chk("R10 read data", rd_data, pat);
    @(negedge clk);
    chk("R10 done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; cfg_setup = '0; cfg_hold = '0; cfg_wait = '0; cfg_bs_hold = 1'b0;
    cfg_width = 2'd2; ext_rdy = 1'b1; rd_pat = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 cs_n", 32'(bus_cs_n), 32'd1);
    chk("R11 rd_n", 32'(bus_rd_n), 32'd1);
    chk("R11 we_n", 32'(bus_we_n), 32'hF);
    chk("R11 bs_n", 32'(bus_bs_n), 32'd1);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 ready", 32'(req_ready), 32'd1);
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic logic [22:0] v = VECS[i];
      run_access(v[22], v[21:20], v[19:18], v[17:16], int'(v[15:13]), int'(v[12:10]),
                 int'(v[9:5]), v[4], v[3:0], 0, 32'h5A00_0000 + 32'(i));
    end

    // R1 area miss
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {3'b101, 26'h0000010};
    req_size = 2'd2; cfg_setup = 3'd1; cfg_wait = 5'd1;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      logic miss_bad = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (!bus_cs_n || done || !req_ready || bus_we_n != 4'hF) miss_bad = 1'b1;
        @(negedge clk);
      end
      chk("R1 out-of-area request ignored", 32'(miss_bad), 32'd0);
    end

    // R5 ready held low with zero waits
    ext_rdy = 1'b0;
    repeat (3) @(negedge clk);
    run_access(1'b1, 2'd2, 2'd0, 2'd2, 1, 1, 0, 1'b0, 4'b1111, 0, 32'h1111_0000);
    run_access(1'b0, 2'd0, 2'd2, 2'd2, 0, 0, 0, 1'b0, 4'b0100, 0, 32'h2222_0000);

    // R4 ready extension: raised in strobe cycle 6, waits 2 -> 8 strobe cycles
    run_access(1'b1, 2'd2, 2'd0, 2'd2, 1, 1, 2, 1'b0, 4'b1111, 6, 32'h3333_0000);
    ext_rdy = 1'b0;
    repeat (3) @(negedge clk);
    run_access(1'b0, 2'd1, 2'd0, 2'd1, 2, 0, 1, 1'b1, 4'b0011, 4, 32'h4444_0000);
    ext_rdy = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule